// File: doc/BRIEF.md
# Prioritised Interrupt Concentrator

This block merges thirty-four interrupt sources into a single request line towards the processor. Twenty-six sources come from on-chip peripherals as active-high set strobes. Eight come from external pins, which are active low. Each source owns a pending flag and a mask flag. A registered vector reports the most urgent source that is pending and not masked. Software reaches all state through a small word-wide register port. Pending flags are cleared by writing ones.

The urgency order can be programmed and changed while the block runs. Sources 0..2 are fast channels and sources 3..6 are slower channels. Each channel carries a slot number, and the slot number fixes its place within its own set. In the grouped arrangement both channel sets sit above every other source, with the slower set directly below the fast set. In the spread arrangement the channel slots are interleaved among the other sources across the whole list. One source can be promoted above everything else.

A small two-state machine guards against a race between masking and requesting. It starts in `ST_NORMAL`. The RACE transition moves it to `ST_ERR_HOLD` when a mask write hides a source that is pending and visible at that moment. The ACK transition returns it to `ST_NORMAL` when software reads the vector register. While it is in `ST_ERR_HOLD`, the vector shows a fixed error code and the request line stays high, whatever the masks say.

Top module: `irqc_concentrator`

## Requirements
- R1: `irq` is registered. It goes high one cycle after any source is both pending and unmasked, or after the block enters `ST_ERR_HOLD`. Otherwise it is low.
- R2: A pending flag is set in the cycle after its source asserts. It stays set until a 1 is written to its bit at address 0 (sources 0..31) or address 1 (bits 1:0 = sources 32..33). Writing 0 leaves the flag unchanged.
- R3: When a source asserts in the same cycle as a write-one clear of its flag, the flag remains set.
- R4: A mask bit of 1 (address 2 = sources 0..31, address 3 bits 1:0 = sources 32..33; reset value all ones) keeps the source out of `irq` and out of the vector, while its pending flag still records events.
- R5: `vec_code` is a register. It holds 1 + the index of the winning source, or 0 when no source is pending and unmasked. It reflects the state one cycle earlier.
- R6: Grouped arrangement (address 4 bit 8 = 0): fast channel c ranks at its slot, slow channel c ranks at 8 + its slot, and other source j (index 7 + j) ranks at 16 + 4j. The lowest rank wins.
- R7: Spread arrangement (address 4 bit 8 = 1): a fast channel ranks at 17 + 36 x slot, a slow channel at 18 + 24 x slot, and other sources keep 16 + 4j.
- R8: Address 5 holds the 2-bit slots. Fast channel c is at bits 2c+1:2c and slow channel c at bits 17+2c:16+2c. Each resets to its channel number. Equal ranks are decided for the lower source index. A new setting takes effect on the next vector.
- R9: A code k of 1..34 in address 4 bits 5:0 makes source k-1 win whenever it is pending and unmasked. A value of 0 disables this.
- R10: A mask write that sets the mask bit of a pending, previously unmasked source makes `vec_code` read 63 and holds `irq` high. This lasts until a read with `rd_en` at address 7. A new race in the same cycle as that read takes precedence.
- R11: Each pin passes through two flops that reset to 1. In level mode (address 6 bit e = 0) the pending flag of source 26+e is set in every cycle that the synchronised pin is low.
- R12: In edge mode (address 6 bit e = 1) the flag is set once per falling edge of the synchronised pin. Holding the pin low does not set it again.
- R13: Reads are combinational from `addr`: pending words, mask words, control, slots, edge selects, and at address 7 the vector in bits 5:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; at address 7 it acknowledges an error vector |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| int_src | input | 26 | Active-high set strobes from on-chip peripherals (sources 0..25) |
| ext_n | input | 8 | Active-low external pins (sources 26..33) |
| irq | output | 1 | Combined request to the processor |
| vec_code | output | 6 | Registered winning source code, 0 for none, 63 for error |

## Verification
The assertions assume that inputs change only away from the rising edge and that the external pins are high while reset is applied, so that the edge detector never sees a false fall on release. They also assume that `wdata` matters only when `wr_en` is high. The stimulus drives every input on the falling clock edge, holds the pins high through reset, and raises a strobe, a clear or a mask write for single cycles at a time. The one exception is the deliberate overlap of a strobe with its own clear. A behavioural reference model tracks pending flags, masks, the error hold and the pin synchronisers, and it predicts `irq` and `vec_code` for every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int DATA_W = 32;
    localparam int CODE_W = 6;
    localparam logic [CODE_W-1:0] ERR_CODE = '1;

    typedef enum logic [2:0] {
        A_PEND_LO = 3'd0,
        A_PEND_HI = 3'd1,
        A_MASK_LO = 3'd2,
        A_MASK_HI = 3'd3,
        A_CTRL    = 3'd4,
        A_SLOT    = 3'd5,
        A_EDGE    = 3'd6,
        A_VEC     = 3'd7
    } reg_addr_e;

    typedef enum logic [0:0] {
        ST_NORMAL   = 1'b0,
        ST_ERR_HOLD = 1'b1
    } err_state_e;

endpackage

// File: rtl/irqc_pin_sync.sv
module irqc_pin_sync #(
    parameter int NUM_EXT = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EXT-1:0] ext_n,
    input  logic [NUM_EXT-1:0] edge_sel,
    output logic [NUM_EXT-1:0] ext_set
);

    for (genvar e = 0; e < NUM_EXT; e++) begin : g_pin
        logic meta_q;
        logic sync_q;
        logic prev_q;
        logic fall;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= ext_n[e];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign fall       = prev_q & ~sync_q;
        assign ext_set[e] = edge_sel[e] ? fall : ~sync_q;

        // a falling edge is reported for one cycle only
        p_fall_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
            fall |=> !fall);
    end

endmodule

// File: rtl/irqc_resolver.sv
module irqc_resolver
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 34,
    parameter int NUM_FAST = 3,
    parameter int NUM_SLOW = 4,
    parameter int SLOT_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         active,
    input  logic [CODE_W-1:0]          top_code,
    input  logic                       spread,
    input  logic [NUM_FAST*SLOT_W-1:0] fast_slots,
    input  logic [NUM_SLOW*SLOT_W-1:0] slow_slots,
    output logic [CODE_W-1:0]          win_code
);

    localparam int NUM_MISC  = NUM_SRC - NUM_FAST - NUM_SLOW;
    localparam int FAST_STEP = 4 * (NUM_MISC / NUM_FAST);
    localparam int SLOW_STEP = 4 * (NUM_MISC / NUM_SLOW);
    localparam int SLOW_BASE = 8;
    localparam int MISC_BASE = 16;
    localparam int RANK_W    = 8;
    localparam int KEY_W     = RANK_W + 1;

    logic [KEY_W-1:0] key [NUM_SRC];

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_key
        logic [RANK_W-1:0] rank;
        if (i < NUM_FAST) begin : g_fast
            logic [SLOT_W-1:0] slot;
            assign slot = fast_slots[i*SLOT_W +: SLOT_W];
            assign rank = spread
                ? RANK_W'(MISC_BASE + 1) + RANK_W'(slot) * RANK_W'(FAST_STEP)
                : RANK_W'(slot);
        end else if (i < NUM_FAST + NUM_SLOW) begin : g_slow
            logic [SLOT_W-1:0] slot;
            assign slot = slow_slots[(i-NUM_FAST)*SLOT_W +: SLOT_W];
            assign rank = spread
                ? RANK_W'(MISC_BASE + 2) + RANK_W'(slot) * RANK_W'(SLOW_STEP)
                : RANK_W'(SLOW_BASE) + RANK_W'(slot);
        end else begin : g_misc
            assign rank = RANK_W'(MISC_BASE + 4 * (i - NUM_FAST - NUM_SLOW));
        end
        assign key[i] = {(top_code != CODE_W'(i + 1)), rank};
    end

    always_comb begin
        logic             found;
        logic [KEY_W-1:0] best_key;
        found    = 1'b0;
        best_key = '1;
        win_code = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (active[i] && (!found || key[i] < best_key)) begin
                found    = 1'b1;
                best_key = key[i];
                win_code = CODE_W'(i + 1);
            end
        end
    end

    p_winner_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (win_code != '0) |-> active[win_code - 1'b1]);

    p_top_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_code != '0) && (top_code <= NUM_SRC) && active[top_code - 1'b1])
            |-> (win_code == top_code));

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 34,
    parameter int NUM_FAST = 3,
    parameter int NUM_SLOW = 4,
    parameter int NUM_EXT  = 8,
    parameter int SLOT_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       rd_en,
    input  logic [2:0]                 addr,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NUM_SRC-1:0]         src_set,
    input  logic [CODE_W-1:0]          win_code,
    output logic [NUM_SRC-1:0]         active,
    output logic [CODE_W-1:0]          top_code,
    output logic                       spread,
    output logic [NUM_FAST*SLOT_W-1:0] fast_slots,
    output logic [NUM_SLOW*SLOT_W-1:0] slow_slots,
    output logic [NUM_EXT-1:0]         edge_sel,
    output logic                       irq,
    output logic [CODE_W-1:0]          vec_code
);

    localparam int HI_W       = NUM_SRC - DATA_W;
    localparam int FAST_BITS  = NUM_FAST * SLOT_W;
    localparam int SLOW_BITS  = NUM_SLOW * SLOT_W;
    localparam int SLOW_LSB   = 16;
    localparam int SPREAD_BIT = 8;

    function automatic logic [FAST_BITS-1:0] fast_ident();
        logic [FAST_BITS-1:0] r;
        for (int c = 0; c < NUM_FAST; c++) r[c*SLOT_W +: SLOT_W] = SLOT_W'(c);
        return r;
    endfunction

    function automatic logic [SLOW_BITS-1:0] slow_ident();
        logic [SLOW_BITS-1:0] r;
        for (int c = 0; c < NUM_SLOW; c++) r[c*SLOT_W +: SLOT_W] = SLOT_W'(c);
        return r;
    endfunction

    logic [NUM_SRC-1:0]   pend_q, mask_q, clr, mask_d;
    logic [CODE_W-1:0]    top_q, vec_q;
    logic                 spread_q, irq_q;
    logic [FAST_BITS-1:0] fslot_q;
    logic [SLOW_BITS-1:0] sslot_q;
    logic [NUM_EXT-1:0]   edge_q;
    logic                 race, vec_ack;
    err_state_e           state_q, state_d;

    // write decode for the flag words
    always_comb begin
        clr    = '0;
        mask_d = mask_q;
        if (wr_en) begin
            unique case (addr)
                A_PEND_LO: clr[DATA_W-1:0]       = wdata;
                A_PEND_HI: clr[NUM_SRC-1:DATA_W] = wdata[HI_W-1:0];
                A_MASK_LO: mask_d[DATA_W-1:0]    = wdata;
                A_MASK_HI: mask_d[NUM_SRC-1:DATA_W] = wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    assign race    = |(mask_d & ~mask_q & pend_q);
    assign vec_ack = rd_en && (addr == A_VEC);
    assign active  = pend_q & ~mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            mask_q   <= '1;
            top_q    <= '0;
            spread_q <= 1'b0;
            fslot_q  <= fast_ident();
            sslot_q  <= slow_ident();
            edge_q   <= '0;
        end else begin
            pend_q <= (pend_q & ~clr) | src_set;
            mask_q <= mask_d;
            if (wr_en && addr == A_CTRL) begin
                top_q    <= wdata[CODE_W-1:0];
                spread_q <= wdata[SPREAD_BIT];
            end
            if (wr_en && addr == A_SLOT) begin
                fslot_q <= wdata[FAST_BITS-1:0];
                sslot_q <= wdata[SLOW_LSB +: SLOW_BITS];
            end
            if (wr_en && addr == A_EDGE) edge_q <= wdata[NUM_EXT-1:0];
        end
    end

    // error-hold state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL:   if (race) state_d = ST_ERR_HOLD;
            ST_ERR_HOLD: if (vec_ack && !race) state_d = ST_NORMAL;
            default:     state_d = ST_NORMAL;
        endcase
    end

    // error-hold state machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
            irq_q <= 1'b0;
        end else begin
            vec_q <= (state_q == ST_ERR_HOLD) ? ERR_CODE : win_code;
            irq_q <= (state_q == ST_ERR_HOLD) || (|active);
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_PEND_LO: rdata = pend_q[DATA_W-1:0];
            A_PEND_HI: rdata[HI_W-1:0] = pend_q[NUM_SRC-1:DATA_W];
            A_MASK_LO: rdata = mask_q[DATA_W-1:0];
            A_MASK_HI: rdata[HI_W-1:0] = mask_q[NUM_SRC-1:DATA_W];
            A_CTRL: begin
                rdata[CODE_W-1:0]  = top_q;
                rdata[SPREAD_BIT]  = spread_q;
            end
            A_SLOT: begin
                rdata[FAST_BITS-1:0]           = fslot_q;
                rdata[SLOW_LSB +: SLOW_BITS]   = sslot_q;
            end
            A_EDGE:  rdata[NUM_EXT-1:0] = edge_q;
            A_VEC:   rdata[CODE_W-1:0]  = vec_q;
            default: rdata = '0;
        endcase
    end

    assign top_code   = top_q;
    assign spread     = spread_q;
    assign fast_slots = fslot_q;
    assign slow_slots = sslot_q;
    assign edge_sel   = edge_q;
    assign irq        = irq_q;
    assign vec_code   = vec_q;

    p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((pend_q & $past(src_set)) == $past(src_set)));

    p_err_vector_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ERR_HOLD) |=> (vec_q == ERR_CODE));

    p_irq_vec_agree_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q == (vec_q != '0));

    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (addr == A_MASK_LO || addr == A_MASK_HI)) |=> $stable(mask_q));

endmodule

// File: rtl/irqc_concentrator.sv
module irqc_concentrator
    import irqc_pkg::*;
#(
    parameter int NUM_SRC  = 34,
    parameter int NUM_FAST = 3,
    parameter int NUM_SLOW = 4,
    parameter int NUM_EXT  = 8,
    parameter int SLOT_W   = 2,
    localparam int NUM_INT = NUM_SRC - NUM_EXT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [2:0]         addr,
    input  logic [31:0]        wdata,
    output logic [31:0]        rdata,
    input  logic [NUM_INT-1:0] int_src,
    input  logic [NUM_EXT-1:0] ext_n,
    output logic               irq,
    output logic [5:0]         vec_code
);

    logic [NUM_EXT-1:0]         ext_set, edge_sel;
    logic [NUM_SRC-1:0]         src_set, active;
    logic [CODE_W-1:0]          win_code, top_code;
    logic                       spread;
    logic [NUM_FAST*SLOT_W-1:0] fast_slots;
    logic [NUM_SLOW*SLOT_W-1:0] slow_slots;

    irqc_pin_sync #(.NUM_EXT(NUM_EXT)) u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_n    (ext_n),
        .edge_sel (edge_sel),
        .ext_set  (ext_set)
    );

    assign src_set = {ext_set, int_src};

    irqc_regs #(
        .NUM_SRC(NUM_SRC), .NUM_FAST(NUM_FAST), .NUM_SLOW(NUM_SLOW),
        .NUM_EXT(NUM_EXT), .SLOT_W(SLOT_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .src_set    (src_set),
        .win_code   (win_code),
        .active     (active),
        .top_code   (top_code),
        .spread     (spread),
        .fast_slots (fast_slots),
        .slow_slots (slow_slots),
        .edge_sel   (edge_sel),
        .irq        (irq),
        .vec_code   (vec_code)
    );

    irqc_resolver #(
        .NUM_SRC(NUM_SRC), .NUM_FAST(NUM_FAST), .NUM_SLOW(NUM_SLOW), .SLOT_W(SLOT_W)
    ) u_resolve (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (active),
        .top_code   (top_code),
        .spread     (spread),
        .fast_slots (fast_slots),
        .slow_slots (slow_slots),
        .win_code   (win_code)
    );

endmodule

// File: tb/irqc_concentrator_test.sv
`timescale 1ns/1ps
module irqc_concentrator_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [25:0] int_src = '0;
    logic [7:0]  ext_n = '1;
    logic        irq;
    logic [5:0]  vec_code;

    always #2.5 clk = ~clk;

    irqc_concentrator uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .int_src(int_src), .ext_n(ext_n),
        .irq(irq), .vec_code(vec_code)
    );

    int    n_checks = 0, n_fail = 0, cycles = 0;
    bit    started = 0, done = 0;
    string cur_req = "R13";

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [33:0] m_pend, m_mask;
    logic [31:0] m_ctrl, m_slot;
    logic [7:0]  m_edge, m_s1, m_s2, m_prev;
    bit          m_err;
    int          exp_vec;
    bit          exp_irq;

    function automatic int rank_of(int i);
        int slot, r;
        if (i < 3) begin
            slot = int'((m_slot >> (2*i)) & 3);
            r = m_ctrl[8] ? 17 + 36*slot : slot;
        end else if (i < 7) begin
            slot = int'((m_slot >> (16 + 2*(i-3))) & 3);
            r = m_ctrl[8] ? 18 + 24*slot : 8 + slot;
        end else begin
            r = 16 + 4*(i-7);
        end
        if (int'(m_ctrl[5:0]) == i + 1) r = -1;
        return r;
    endfunction

    function automatic int best_of(logic [33:0] act);
        int best = 0, bk = 1000;
        for (int i = 0; i < 34; i++)
            if (act[i] && rank_of(i) < bk) begin bk = rank_of(i); best = i + 1; end
        return best;
    endfunction

    always @(posedge clk) begin
        logic [33:0] act, setv, clr, mnew;
        if (!rst_n) begin
            m_pend = '0; m_mask = '1; m_ctrl = '0; m_slot = 32'h00E40024;
            m_edge = '0; m_s1 = '1; m_s2 = '1; m_prev = '1; m_err = 0;
            exp_vec = 0; exp_irq = 0;
        end else begin
            act     = m_pend & ~m_mask;
            exp_vec = m_err ? 63 : best_of(act);
            exp_irq = m_err || (act != 0);
            setv = {8'h00, int_src};
            for (int e = 0; e < 8; e++)
                setv[26+e] = m_edge[e] ? (m_prev[e] & ~m_s2[e]) : ~m_s2[e];
            clr = '0; mnew = m_mask;
            if (wr_en && addr == 0) clr[31:0] = wdata;
            if (wr_en && addr == 1) clr[33:32] = wdata[1:0];
            if (wr_en && addr == 2) mnew[31:0] = wdata;
            if (wr_en && addr == 3) mnew[33:32] = wdata[1:0];
            if ((mnew & ~m_mask & m_pend) != 0) m_err = 1;
            else if (rd_en && addr == 7) m_err = 0;
            m_pend = (m_pend & ~clr) | setv;
            m_mask = mnew;
            if (wr_en && addr == 4) m_ctrl = wdata & 32'h0000013F;
            if (wr_en && addr == 5) m_slot = wdata & 32'h00FF003F;
            if (wr_en && addr == 6) m_edge = wdata[7:0];
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_n;
        end
    end

    function automatic longint model_read(int a);
        case (a)
            0: return longint'(m_pend[31:0]);
            1: return longint'(m_pend[33:32]);
            2: return longint'(m_mask[31:0]);
            3: return longint'(m_mask[33:32]);
            4: return longint'(m_ctrl);
            5: return longint'(m_slot);
            6: return longint'(m_edge);
            default: return longint'(exp_vec);
        endcase
    endfunction

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            check(vec_code == 6'(exp_vec), cur_req, "vec_code per cycle (R5)", vec_code, exp_vec);
            check(irq == exp_irq, cur_req, "irq per cycle (R1)", irq, exp_irq);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); wr_en = 1; addr = 3'(a); wdata = d;
        @(negedge clk); wr_en = 0; wdata = '0;
    endtask

    task automatic rd(input int a, input longint exp, input string req);
        @(negedge clk); addr = 3'(a); #1;
        check(longint'(rdata) == exp, req, $sformatf("read addr %0d", a), rdata, exp);
        check(longint'(rdata) == model_read(a), req, "read vs model", rdata, model_read(a));
    endtask

    task automatic pulse(input int b);
        @(negedge clk); int_src[b] = 1'b1;
        @(negedge clk); int_src[b] = 1'b0;
    endtask

    task automatic expect_out(input int v, input bit q, input string req);
        check(vec_code == 6'(v), req, "vec_code", vec_code, v);
        check(irq == q, req, "irq", irq, q);
    endtask

    task automatic clear_all();
        wr(0, 32'hFFFF_FFFF); wr(1, 32'h3); idle(2);
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        started = 1;
        idle(2);
        cur_req = "R13";
        expect_out(0, 0, "R13 reset");
        rd(2, 64'hFFFF_FFFF, "R4 mask reset");
        rd(5, 64'h00E4_0024, "R8 slot reset");
        rd(4, 0, "R13 ctrl reset");
        wr(2, 0); wr(3, 0);

        cur_req = "R2";
        pulse(20); idle(2);
        expect_out(21, 1, "R2 set");
        rd(0, 64'h0010_0000, "R2");
        wr(0, 0); idle(2);
        rd(0, 64'h0010_0000, "R2 zero write");
        wr(0, 32'h0010_0000); idle(2);
        expect_out(0, 0, "R2 cleared");

        cur_req = "R3";
        @(negedge clk); int_src[5] = 1;
        @(negedge clk); wr_en = 1; addr = 3'd0; wdata = 32'h20;
        @(negedge clk); wr_en = 0; wdata = 0; int_src[5] = 0;
        idle(2);
        rd(0, 64'h20, "R3 set wins");
        wr(0, 32'h20); idle(2);
        rd(0, 0, "R3 cleared");

        cur_req = "R4";
        wr(2, 32'h0010_0000);
        pulse(20); idle(2);
        expect_out(0, 0, "R4 masked");
        rd(0, 64'h0010_0000, "R4 still pending");
        wr(0, 32'h0010_0000); wr(2, 0);

        cur_req = "R6";
        pulse(1); pulse(3); pulse(7); idle(2);
        expect_out(2, 1, "R6 fast first");
        wr(0, 32'h2); idle(2);
        expect_out(4, 1, "R6 slow above other");
        clear_all();

        cur_req = "R8";
        wr(5, 32'h00E4_0006);
        pulse(0); pulse(2); idle(2);
        expect_out(3, 1, "R8 reordered");
        wr(5, 32'h00E4_0004); idle(2);
        expect_out(1, 1, "R8 tie lower index");
        wr(5, 32'h00E4_0024);
        clear_all();

        cur_req = "R7";
        pulse(3); pulse(7); idle(2);
        expect_out(4, 1, "R6 grouped");
        wr(4, 32'h100); idle(2);
        expect_out(8, 1, "R7 spread");
        pulse(0); idle(2);
        expect_out(8, 1, "R7 spread fast");
        wr(0, 32'h80); idle(2);
        expect_out(1, 1, "R7 fast over slow");
        wr(4, 0);
        clear_all();

        cur_req = "R9";
        pulse(0); pulse(25); idle(2);
        expect_out(1, 1, "R9 before");
        wr(4, 26); idle(2);
        expect_out(26, 1, "R9 top");
        wr(4, 0);
        clear_all();

        cur_req = "R10";
        pulse(10); idle(2);
        expect_out(11, 1, "R10 before");
        wr(2, 32'hFFFF_FFFF); idle(2);
        expect_out(63, 1, "R10 error vector");
        idle(3);
        expect_out(63, 1, "R10 held");
        @(negedge clk); addr = 3'd7; rd_en = 1; #1;
        check(rdata == 32'd63, "R13", "vector readback", rdata, 63);
        @(negedge clk); rd_en = 0;
        idle(2);
        expect_out(0, 0, "R10 acknowledged");
        wr(0, 32'h400); wr(2, 0);

        cur_req = "R11";
        @(negedge clk); ext_n[0] = 0;
        idle(5);
        rd(0, 64'h0400_0000, "R11 level");
        expect_out(27, 1, "R11 vector");
        wr(0, 32'h0400_0000); idle(2);
        rd(0, 64'h0400_0000, "R11 still low");
        @(negedge clk); ext_n[0] = 1;
        idle(4);
        wr(0, 32'h0400_0000); idle(2);
        rd(0, 0, "R11 released");

        cur_req = "R12";
        wr(6, 32'h2);
        @(negedge clk); ext_n[1] = 0;
        idle(5);
        rd(0, 64'h0800_0000, "R12 edge");
        wr(0, 32'h0800_0000); idle(4);
        rd(0, 0, "R12 held low no retrigger");
        @(negedge clk); ext_n[1] = 1;
        idle(4);
        @(negedge clk); ext_n[1] = 0;
        idle(5);
        rd(0, 64'h0800_0000, "R12 second edge");
        @(negedge clk); ext_n[1] = 1;
        idle(4);
        clear_all();
        expect_out(0, 0, "R1 idle");

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule